// File: doc/BRIEF.md
# Output Compare Channel With Pin Action

This block is a single output compare channel that sits beside a free-running count. It keeps a compare value, and on each count step where the count equals that value it does three things. It sets a sticky status flag. It may raise an interrupt request. It updates its output pin according to a two-bit action code.

Software loads the compare value, the action code and the interrupt enable. It clears the flag by writing a one to it. A force strobe applies the configured pin action at once, without a match and without touching the flag.

A typical use produces a square wave. Software programs the toggle action. Each time the flag comes up, it adds a half-period to the compare value and clears the flag. Because the pin edge is placed by the hardware match, the period stays exact however late the service runs, as long as the service completes within a half-period.

Top module: `ocChannel`

## Requirements
- R1: When `cntTick` is high and `cntValue` equals the compare value, the pin action and the flag update take effect at the next rising clock edge.
- R2: Action code 2'b00 leaves the pin unchanged, 2'b01 inverts it, 2'b10 drives it to 0 and 2'b11 drives it to 1.
- R3: A match sets `flagOut`, and the flag stays set until software clears it.
- R4: `irqReq` is high exactly when the flag is set and the interrupt enable is 1.
- R5: A flag write (`flagWr`) with `flagWrData`=1 clears the flag, and a flag write with 0 leaves it unchanged. If a match and a clear land in the same cycle, the flag ends up set.
- R6: `forceStb` applies the configured action at the next edge and does not set the flag. If a force and a match land in the same cycle, the action is applied once.
- R7: No action and no flag change happen in a cycle with `cntTick` low, even if `cntValue` equals the compare value.
- R8: Reset state:
  - compare value 16'hFFFF;
  - action code 2'b00;
  - interrupt enable 0;
  - flag 0;
  - pin 0.
- R9: A compare write (`cmpWrEn`) is visible on `cmpValue` after the next edge. Rewriting the compare value by a fixed half-period on each flag gives a toggle waveform whose pin edges are exactly that many counts apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | High in cycles where the count has taken a new value |
| cntValue | input | 16 | Free-running count |
| cmpWrEn | input | 1 | Compare value write strobe |
| cmpWrData | input | 16 | Compare value to load |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAction | input | 2 | Pin action code to load |
| cfgIrqEn | input | 1 | Interrupt enable to load |
| flagWr | input | 1 | Flag register write strobe |
| flagWrData | input | 1 | Flag write data, 1 clears |
| forceStb | input | 1 | Force-compare strobe |
| cmpValue | output | 16 | Current compare value |
| flagOut | output | 1 | Match status flag |
| irqReq | output | 1 | Interrupt request |
| pinOut | output | 1 | Compare output pin |

## Verification
Any wrong match decision shows up on `pinOut` and `flagOut` one edge after the offending count step. Examples are a repeated action while the count is held, or a missed equality. A corrupted action code or a lost flag clear also shows within one cycle at those ports and at `irqReq`. An off-by-one in compare loading shows up only later, as a toggle interval that differs from the programmed half-period. The periodic test therefore measures several successive intervals.

// File: rtl/ocPkg.sv
package ocPkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pinAction_e;

  typedef struct packed {
    logic applyAction;
    logic setFlag;
    logic clrFlag;
    logic loadCmp;
    logic loadCfg;
  } ocStrobes_t;
endpackage

// File: rtl/ocCtrl.sv
module ocCtrl
  import ocPkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntTick,
  input  logic [W-1:0] cntValue,
  input  logic [W-1:0] cmpValue,
  input  logic         cmpWrEn,
  input  logic         cfgWrEn,
  input  logic         flagWr,
  input  logic         flagWrData,
  input  logic         forceStb,
  output ocStrobes_t   stb
);
  logic isMatch;

  // Equality only counts on the cycle the count steps.
  assign isMatch = cntTick && (cntValue == cmpValue);

  always_comb begin
    stb             = '0;
    stb.applyAction = isMatch || forceStb;
    stb.setFlag     = isMatch;
    stb.clrFlag     = flagWr && flagWrData;
    stb.loadCmp     = cmpWrEn;
    stb.loadCfg     = cfgWrEn;
  end

  // R7: without a count step or force, nothing is applied
  a_r7_no_tick_no_action : assert property (@(posedge clk) disable iff (!rstN)
    (!cntTick && !forceStb) |-> !stb.applyAction);

  // R6: a force alone never sets the flag
  a_r6_force_no_flag : assert property (@(posedge clk) disable iff (!rstN)
    (forceStb && !cntTick) |-> !stb.setFlag);
endmodule

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocPkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ocStrobes_t   stb,
  input  logic [W-1:0] cmpWrData,
  input  logic [1:0]   cfgAction,
  input  logic         cfgIrqEn,
  output logic [W-1:0] cmpValue,
  output logic         flagOut,
  output logic         irqReq,
  output logic         pinOut
);
  localparam logic [W-1:0] CMP_RST = '1;

  logic [W-1:0] cmpReg;
  pinAction_e   actReg;
  logic         irqEnReg;
  logic         flagReg;
  logic         pinReg;
  logic         pinNext;

  always_comb begin
    pinNext = pinReg;
    if (stb.applyAction) begin
      unique case (actReg)
        ACT_NONE:   pinNext = pinReg;
        ACT_TOGGLE: pinNext = !pinReg;
        ACT_LOW:    pinNext = 1'b0;
        ACT_HIGH:   pinNext = 1'b1;
        default:    pinNext = pinReg;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg   <= CMP_RST;
      actReg   <= ACT_NONE;
      irqEnReg <= 1'b0;
      flagReg  <= 1'b0;
      pinReg   <= 1'b0;
    end else begin
      if (stb.loadCmp) cmpReg <= cmpWrData;
      if (stb.loadCfg) begin
        actReg   <= pinAction_e'(cfgAction);
        irqEnReg <= cfgIrqEn;
      end
      if (stb.setFlag)      flagReg <= 1'b1;
      else if (stb.clrFlag) flagReg <= 1'b0;
      pinReg <= pinNext;
    end
  end

  assign cmpValue = cmpReg;
  assign flagOut  = flagReg;
  assign irqReq   = flagReg && irqEnReg;
  assign pinOut   = pinReg;

  // R2: toggle action inverts the pin
  a_r2_toggle_inverts : assert property (@(posedge clk) disable iff (!rstN)
    (stb.applyAction && actReg == ACT_TOGGLE) |=> (pinReg != $past(pinReg)));

  // R2: no-change action holds the pin
  a_r2_none_holds : assert property (@(posedge clk) disable iff (!rstN)
    (actReg == ACT_NONE && !stb.loadCfg) |=> $stable(pinReg));

  // R3: a match sets the flag, and set wins over clear (R5)
  a_r3_flag_set : assert property (@(posedge clk) disable iff (!rstN)
    stb.setFlag |=> flagReg);

  // R5: a clear alone drops the flag
  a_r5_flag_clear : assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrFlag && !stb.setFlag) |=> !flagReg);

  // R3: the flag never rises without a match
  a_r3_no_spurious_flag : assert property (@(posedge clk) disable iff (!rstN)
    (!stb.setFlag && !flagReg) |=> !flagReg);

  // R4: a request always implies a set flag
  a_r4_irq_needs_flag : assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> flagReg);
endmodule

// File: rtl/ocChannel.sv
module ocChannel
  import ocPkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntTick,
  input  logic [W-1:0] cntValue,
  input  logic         cmpWrEn,
  input  logic [W-1:0] cmpWrData,
  input  logic         cfgWrEn,
  input  logic [1:0]   cfgAction,
  input  logic         cfgIrqEn,
  input  logic         flagWr,
  input  logic         flagWrData,
  input  logic         forceStb,
  output logic [W-1:0] cmpValue,
  output logic         flagOut,
  output logic         irqReq,
  output logic         pinOut
);
  ocStrobes_t stb;

  ocCtrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .cntValue(cntValue),
    .cmpValue(cmpValue), .cmpWrEn(cmpWrEn), .cfgWrEn(cfgWrEn),
    .flagWr(flagWr), .flagWrData(flagWrData), .forceStb(forceStb),
    .stb(stb)
  );

  ocDatapath #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpWrData(cmpWrData),
    .cfgAction(cfgAction), .cfgIrqEn(cfgIrqEn), .cmpValue(cmpValue),
    .flagOut(flagOut), .irqReq(irqReq), .pinOut(pinOut)
  );
endmodule

// File: tb/ocChannel_tb.sv
module ocChannel_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntTick = 1'b0;
  logic [15:0] cntValue = '0;
  logic        cmpWrEn = 1'b0;
  logic [15:0] cmpWrData = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAction = '0;
  logic        cfgIrqEn = 1'b0;
  logic        flagWr = 1'b0;
  logic        flagWrData = 1'b0;
  logic        forceStb = 1'b0;
  logic [15:0] cmpValue;
  logic        flagOut, irqReq, pinOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ocChannel dut_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .cntValue(cntValue),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .cfgWrEn(cfgWrEn),
    .cfgAction(cfgAction), .cfgIrqEn(cfgIrqEn), .flagWr(flagWr),
    .flagWrData(flagWrData), .forceStb(forceStb), .cmpValue(cmpValue),
    .flagOut(flagOut), .irqReq(irqReq), .pinOut(pinOut)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // Each helper drives at a falling edge and returns at the next falling edge.
  task automatic setCmp(logic [15:0] v);
    @(negedge clk); cmpWrEn = 1; cmpWrData = v;
    @(negedge clk); cmpWrEn = 0;
  endtask

  task automatic setCfg(logic [1:0] a, logic ie);
    @(negedge clk); cfgWrEn = 1; cfgAction = a; cfgIrqEn = ie;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic tickAt(logic [15:0] v);
    @(negedge clk); cntValue = v; cntTick = 1;
    @(negedge clk); cntTick = 0;
  endtask

  task automatic writeFlag(logic d);
    @(negedge clk); flagWr = 1; flagWrData = d;
    @(negedge clk); flagWr = 0;
  endtask

  task automatic doForce();
    @(negedge clk); forceStb = 1;
    @(negedge clk); forceStb = 0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R8 cmp", int'(cmpValue), 16'hFFFF);
    check("R8 flag", int'(flagOut), 0);
    check("R8 irq", int'(irqReq), 0);
    check("R8 pin", int'(pinOut), 0);
    // Default action 00 means a match leaves the pin alone.
    tickAt(16'hFFFF);
    check("R8 pin after match", int'(pinOut), 0);
    check("R3 flag after default match", int'(flagOut), 1);
    writeFlag(1);
  endtask

  task automatic testActions();
    setCmp(16'd10);
    check("R9 readback", int'(cmpValue), 10);
    setCfg(2'b11, 1'b0);
    tickAt(16'd9);
    check("R1 no match on unequal", int'(flagOut), 0);
    tickAt(16'd10);
    check("R2 drive high", int'(pinOut), 1);
    check("R3 flag set", int'(flagOut), 1);
    check("R4 irq disabled", int'(irqReq), 0);
    setCfg(2'b11, 1'b1);
    check("R4 irq enabled", int'(irqReq), 1);
    writeFlag(0);
    check("R5 zero write keeps flag", int'(flagOut), 1);
    writeFlag(1);
    check("R5 one write clears", int'(flagOut), 0);
    check("R4 irq follows flag", int'(irqReq), 0);
    setCfg(2'b10, 1'b0);
    tickAt(16'd10);
    check("R2 drive low", int'(pinOut), 0);
    setCfg(2'b01, 1'b0);
    tickAt(16'd10);
    check("R2 toggle 1", int'(pinOut), 1);
    tickAt(16'd10);
    check("R2 toggle 2", int'(pinOut), 0);
    setCfg(2'b00, 1'b0);
    tickAt(16'd10);
    check("R2 no change", int'(pinOut), 0);
    writeFlag(1);
  endtask

  task automatic testHold();
    setCfg(2'b01, 1'b0);
    @(negedge clk); cntValue = 16'd10; cntTick = 0;
    repeat (4) @(negedge clk);
    check("R7 held count pin", int'(pinOut), 0);
    check("R7 held count flag", int'(flagOut), 0);
  endtask

  task automatic testForce();
    setCfg(2'b01, 1'b0);
    doForce();
    check("R6 force toggles", int'(pinOut), 1);
    check("R6 force no flag", int'(flagOut), 0);
    @(negedge clk); forceStb = 1; cntValue = 16'd10; cntTick = 1;
    @(negedge clk); forceStb = 0; cntTick = 0;
    check("R6 force+match single toggle", int'(pinOut), 0);
    check("R6 force+match flag", int'(flagOut), 1);
    writeFlag(1);
    // Set wins over clear.
    @(negedge clk); flagWr = 1; flagWrData = 1; cntValue = 16'd10; cntTick = 1;
    @(negedge clk); flagWr = 0; cntTick = 0;
    check("R5 set wins over clear", int'(flagOut), 1);
    writeFlag(1);
  endtask

  task automatic testPeriodic(int half);
    logic [15:0] nextCmp;
    logic        lastPin;
    int          lastEdge = -1;
    int          edges = 0;
    setCfg(2'b01, 1'b0);
    nextCmp = 16'd100 + 16'(half);
    setCmp(nextCmp);
    lastPin = pinOut;
    for (int i = 0; i < 100 + 6 * half; i++) begin
      @(negedge clk);
      if (pinOut != lastPin) begin
        if (lastEdge >= 0)
          check("R9 toggle interval", i - lastEdge, half);
        lastEdge = i;
        edges++;
        lastPin = pinOut;
      end
      cmpWrEn = 0; flagWr = 0;
      if (flagOut) begin
        nextCmp = nextCmp + 16'(half);
        cmpWrEn = 1; cmpWrData = nextCmp;
        flagWr = 1; flagWrData = 1;
      end
      cntValue = 16'(i); cntTick = 1;
    end
    @(negedge clk); cntTick = 0; cmpWrEn = 0; flagWr = 0;
    check("R9 toggle count", int'(edges >= 4), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testActions();
    testHold();
    testForce();
    testPeriodic(7);
    testPeriodic(13);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule